// File: doc/BRIEF.md
# Offset-Scheduled Carrier Receive Buffer

This block holds the demapped samples of one antenna-carrier channel between the fronthaul deframer and the application. Samples arrive as a 32-bit word with a write strobe and leave through a read strobe. Neither pointer starts because of fill level. Each side is released by a programmable timeslot offset within the 10 ms radio frame. The write side starts storing once the frame position equals its offset. The read side starts draining once the position equals its own offset. With a steady sample stream, the delay through the store is therefore fixed by the difference between the two offsets.

At every radio-frame boundary both sides stop and wait for their offsets again. The write release clears the store level, the write pointer and a container-packing counter. That counter tracks how samples are packed into the carrier container and advances once per stored word. Overflow and underflow are recorded in sticky flags but are never prevented: the write or read goes ahead anyway. A combinational flag reports an offset pair in which the read offset does not come after the write offset. Line framing, register access and clock crossing belong to neighbouring blocks, so a single clock drives everything.

Top module: `carrier_rx_buf`

## Requirements
- R1: While rst_n is low and after it rises, before any other event, rd_valid, rd_data, level, k_cnt, wr_running, rd_running, overflow and underflow are all 0.
- R2: wr_running rises in the cycle after a clock edge that samples frame_pos equal to wr_offset while wr_running is 0. That same edge sets level and k_cnt to 0. wr_data is stored only at edges where wr_running and wr_en are both 1.
- R3: rd_running rises in the cycle after an edge that samples frame_pos equal to rd_offset while rd_running is 0. A read is accepted at an edge where rd_running and rd_en are both 1. rd_valid is 1 exactly in the cycle after an accepted read.
- R4: Words leave in the order they were stored, and rd_data holds the read word in the rd_valid cycle. With a write and a read offered every cycle and frame_pos advancing by one per cycle, the word read at position p is the one written at position p minus (rd_offset − wr_offset). The level then settles at that difference.
- R5: k_cnt is 0 after a write release, increases by 1 for each stored word, and wraps from K_MOD−1 (default 12) to 0.
- R6: A stored word with no accepted read in the same edge while level equals DEPTH (32) sets overflow to 1. The word is still written, and overflow stays 1 until cleared.
- R7: An accepted read while level is 0 sets underflow to 1. The read still takes place with rd_valid 1, and underflow stays 1 until cleared.
- R8: clr_status high at an edge sets overflow and underflow to 0, except for a flag whose set condition occurs at that same edge, which is set.
- R9: An edge where frame_sync is 1 and frame_pos differs from a side's offset stops that side (wr_running or rd_running becomes 0) until its offset is matched again.
- R10: order_err is 1, combinationally, exactly when rd_offset is less than or equal to wr_offset.
- R11: level rises by 1 for a store without a read unless it is at DEPTH. It falls by 1 for a read without a store unless it is at 0. It is unchanged when both or neither happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | High in the cycle of a radio-frame boundary |
| frame_pos | input | POS_W (16) | Current timeslot position within the radio frame |
| wr_offset | input | POS_W (16) | Frame position that releases the write side |
| rd_offset | input | POS_W (16) | Frame position that releases the read side |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | DATA_W (32) | Demapped sample word |
| rd_en | input | 1 | Read strobe from the application |
| clr_status | input | 1 | Clears the sticky overflow and underflow flags |
| rd_data | output | DATA_W (32) | Word read out, valid with rd_valid |
| rd_valid | output | 1 | rd_data carries a word read at the previous edge |
| level | output | clog2(DEPTH+1) (6) | Number of stored words not yet read |
| k_cnt | output | clog2(K_MOD) (4) | Container packing counter |
| wr_running | output | 1 | Write side released |
| rd_running | output | 1 | Read side released |
| overflow | output | 1 | Sticky: a word was stored while full |
| underflow | output | 1 | Sticky: a read was taken while empty |
| order_err | output | 1 | Read offset does not follow write offset |

## Verification
Every registered result (rd_valid, rd_data, level, k_cnt, both running flags and both sticky flags) is due one cycle after the rising edge that samples its stimulus, while order_err follows the offsets within the same cycle. The bench drives inputs on the falling edge and advances a reference model at the rising edge from those held values. It then compares every output at the next falling edge, so each check lands exactly one register stage after its cause. Directed runs pin the offset-difference latency, the fill-to-overflow point, reads from an empty store and the frame-boundary stop. Seeded random frames with changing offsets and strobes then cover the combinations.

// File: rtl/crb_pkg.sv
package crb_pkg;

   // index of each side in the release-unit array
   localparam int SIDE_WR = 0;
   localparam int SIDE_RD = 1;
   localparam int N_SIDES = 2;

   // error events raised by the store in one cycle
   typedef struct packed {
      logic ovf;
      logic unf;
   } fault_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/crb_release.sv
// Releases one side of the buffer when the frame position reaches its offset
// and stops it again at a frame boundary that does not also match.
module crb_release #(
   parameter int POS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync,
   input  logic [POS_W-1:0] frame_pos,
   input  logic [POS_W-1:0] offset,
   output logic             running,
   output logic             launch
);

   logic hit;

   assign hit    = (frame_pos == offset);
   assign launch = hit & ~running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (launch) begin
         running <= 1'b1;
      end else if (frame_sync && !hit) begin
         running <= 1'b0;
      end
   end

endmodule

// File: rtl/crb_kcnt.sv
// Container packing counter: restarts with the write side, one step per word.
module crb_kcnt
   import crb_pkg::*;
#(
   parameter int K_MOD = 12,
   localparam int K_W  = $clog2(K_MOD)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic           step,
   output logic [K_W-1:0] k
);

   logic [K_W-1:0] k_next;

   generate
      if (is_pow2(K_MOD)) begin : g_wrap_free
         // modulus equals the counter range: natural wrap
         assign k_next = k + 1'b1;
      end else begin : g_wrap_cmp
         assign k_next = (k == K_W'(K_MOD - 1)) ? '0 : k + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k <= '0;
      end else if (restart) begin
         k <= '0;
      end else if (step) begin
         k <= k_next;
      end
   end

endmodule

// File: rtl/crb_store.sv
// Circular store with free-running pointers, saturating level and fault events.
module crb_store
   import crb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_restart,
   input  logic              rd_restart,
   input  logic              wr_fire,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_fire,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [LVL_W-1:0]  level,
   output fault_t            fault
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp;
   logic [AW-1:0]     rp;
   logic              full;
   logic              empty;

   assign full  = (level == LVL_W'(DEPTH));
   assign empty = (level == '0);

   // a read beside a store frees a slot, so only a lone store can overflow
   assign fault.ovf = wr_fire & ~rd_fire & full;
   assign fault.unf = rd_fire & empty;

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         mem[wp] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) begin
            rd_data <= mem[rp];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_restart) begin
            wp <= '0;
         end else if (wr_fire) begin
            wp <= wp + 1'b1;
         end
         if (rd_restart) begin
            rp <= '0;
         end else if (rd_fire) begin
            rp <= rp + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else if (wr_restart) begin
         level <= '0;
      end else begin
         unique case ({wr_fire, rd_fire})
            2'b10:   if (!full)  level <= level + 1'b1;
            2'b01:   if (!empty) level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/crb_flags.sv
// Sticky fault flags; a new event wins over a clear in the same cycle.
module crb_flags
   import crb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  fault_t event_in,
   output fault_t sticky
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
      end else begin
         sticky.ovf <= event_in.ovf | (sticky.ovf & ~clr);
         sticky.unf <= event_in.unf | (sticky.unf & ~clr);
      end
   end

endmodule

// File: rtl/carrier_rx_buf.sv
module carrier_rx_buf
   import crb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int POS_W  = 16,
   parameter int K_MOD  = 12,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int K_W   = $clog2(K_MOD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic [POS_W-1:0]  frame_pos,
   input  logic [POS_W-1:0]  wr_offset,
   input  logic [POS_W-1:0]  rd_offset,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              clr_status,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [LVL_W-1:0]  level,
   output logic [K_W-1:0]    k_cnt,
   output logic              wr_running,
   output logic              rd_running,
   output logic              overflow,
   output logic              underflow,
   output logic              order_err
);

   // elaboration-time parameter checks
   generate
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("carrier_rx_buf: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("carrier_rx_buf: DATA_W must be positive");
      end
      if (K_MOD < 2) begin : g_bad_kmod
         $error("carrier_rx_buf: K_MOD must be at least 2");
      end
      if (POS_W < 1) begin : g_bad_pos
         $error("carrier_rx_buf: POS_W must be positive");
      end
   endgenerate

   logic [POS_W-1:0]   side_off [N_SIDES];
   logic [N_SIDES-1:0] side_run;
   logic [N_SIDES-1:0] side_go;
   logic               wr_fire;
   logic               rd_fire;
   fault_t             fault_ev;
   fault_t             fault_st;

   assign side_off[SIDE_WR] = wr_offset;
   assign side_off[SIDE_RD] = rd_offset;

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         crb_release #(.POS_W(POS_W)) u_rel (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_sync (frame_sync),
            .frame_pos  (frame_pos),
            .offset     (side_off[s]),
            .running    (side_run[s]),
            .launch     (side_go[s])
         );
      end
   endgenerate

   assign wr_fire = side_run[SIDE_WR] & wr_en;
   assign rd_fire = side_run[SIDE_RD] & rd_en;

   crb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_restart (side_go[SIDE_WR]),
      .rd_restart (side_go[SIDE_RD]),
      .wr_fire    (wr_fire),
      .wr_data    (wr_data),
      .rd_fire    (rd_fire),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .level      (level),
      .fault      (fault_ev)
   );

   crb_kcnt #(.K_MOD(K_MOD)) u_kcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (side_go[SIDE_WR]),
      .step    (wr_fire),
      .k       (k_cnt)
   );

   crb_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_status),
      .event_in (fault_ev),
      .sticky   (fault_st)
   );

   assign wr_running = side_run[SIDE_WR];
   assign rd_running = side_run[SIDE_RD];
   assign overflow   = fault_st.ovf;
   assign underflow  = fault_st.unf;
   assign order_err  = (rd_offset <= wr_offset);

endmodule

// File: rtl/crb_chk.sv
module crb_chk #(
   parameter int DEPTH  = 32,
   parameter int POS_W  = 16,
   parameter int K_MOD  = 12,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int K_W   = $clog2(K_MOD)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_sync,
   input logic [POS_W-1:0] frame_pos,
   input logic [POS_W-1:0] wr_offset,
   input logic [POS_W-1:0] rd_offset,
   input logic             rd_en,
   input logic             clr_status,
   input logic             rd_valid,
   input logic [LVL_W-1:0] level,
   input logic [K_W-1:0]   k_cnt,
   input logic             wr_running,
   input logic             rd_running,
   input logic             overflow,
   input logic             underflow
);

   // R2
   wr_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_running) |-> $past(frame_pos == wr_offset));

   // R2
   wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_running) |-> (level == '0 && k_cnt == '0));

   // R3
   rd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_running) |-> $past(frame_pos == rd_offset));

   // R3
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_running && rd_en));

   // R5
   k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(k_cnt) < K_MOD);

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clr_status) |=> overflow);

   // R7
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !clr_status) |=> underflow);

   // R9
   wr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_running) |-> $past(frame_sync));

   // R9
   rd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_running) |-> $past(frame_sync));

   // R11
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) <= DEPTH);

endmodule

bind carrier_rx_buf crb_chk #(.DEPTH(DEPTH), .POS_W(POS_W), .K_MOD(K_MOD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_sync (frame_sync),
   .frame_pos  (frame_pos),
   .wr_offset  (wr_offset),
   .rd_offset  (rd_offset),
   .rd_en      (rd_en),
   .clr_status (clr_status),
   .rd_valid   (rd_valid),
   .level      (level),
   .k_cnt      (k_cnt),
   .wr_running (wr_running),
   .rd_running (rd_running),
   .overflow   (overflow),
   .underflow  (underflow)
);

// File: tb/carrier_rx_buf_test.sv
module carrier_rx_buf_test;

   localparam int DATA_W    = 32;
   localparam int DEPTH     = 32;
   localparam int POS_W     = 16;
   localparam int K_MOD     = 12;
   localparam int LVL_W     = $clog2(DEPTH + 1);
   localparam int K_W       = $clog2(K_MOD);
   localparam int FRAME_LEN = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_sync = 1'b0;
   logic [POS_W-1:0]  frame_pos = '0;
   logic [POS_W-1:0]  wr_offset = '0;
   logic [POS_W-1:0]  rd_offset = '0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic              clr_status = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid;
   logic [LVL_W-1:0]  level;
   logic [K_W-1:0]    k_cnt;
   logic              wr_running;
   logic              rd_running;
   logic              overflow;
   logic              underflow;
   logic              order_err;

   carrier_rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .POS_W(POS_W), .K_MOD(K_MOD)) uut (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .frame_pos(frame_pos),
      .wr_offset(wr_offset), .rd_offset(rd_offset), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .clr_status(clr_status), .rd_data(rd_data), .rd_valid(rd_valid),
      .level(level), .k_cnt(k_cnt), .wr_running(wr_running), .rd_running(rd_running),
      .overflow(overflow), .underflow(underflow), .order_err(order_err)
   );

   always #2 clk = ~clk;   // 250 MHz

   int total = 0;
   int bad   = 0;
   int pos   = 0;

   // reference model state
   logic [DATA_W-1:0] m_mem  [DEPTH];
   bit                m_memv [DEPTH];
   logic [DATA_W-1:0] hist   [FRAME_LEN];
   int  m_wp = 0, m_rp = 0, m_lvl = 0, m_k = 0;
   bit  m_wrun = 0, m_rrun = 0, m_ovf = 0, m_unf = 0, m_rv = 0, m_rdv = 0;
   logic [DATA_W-1:0] m_rd = '0;

   task automatic chk(input string tag, input string what, input logic [63:0] got,
                      input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h (pos %0d)", tag, what, got, exp, pos);
      end
   endtask

   // next-state of the model from the inputs held at the rising edge
   task automatic model_step();
      bit wf, rf, full, empty, ovf_ev, unf_ev, wgo, rgo;
      wf     = m_wrun && wr_en;
      rf     = m_rrun && rd_en;
      full   = (m_lvl == DEPTH);
      empty  = (m_lvl == 0);
      ovf_ev = wf && !rf && full;
      unf_ev = rf && empty;
      wgo    = (frame_pos == wr_offset) && !m_wrun;
      rgo    = (frame_pos == rd_offset) && !m_rrun;
      m_rv   = rf;
      if (rf) begin
         m_rd  = m_mem[m_rp];
         m_rdv = m_memv[m_rp];
      end
      if (wf) begin
         m_mem[m_wp]  = wr_data;
         m_memv[m_wp] = 1'b1;
      end
      if (wgo)                     m_lvl = 0;
      else if (wf && !rf && !full) m_lvl = m_lvl + 1;
      else if (rf && !wf && !empty) m_lvl = m_lvl - 1;
      if (wgo)     begin m_wp = 0; m_k = 0; end
      else if (wf) begin m_wp = (m_wp + 1) % DEPTH; m_k = (m_k + 1) % K_MOD; end
      if (rgo)     m_rp = 0;
      else if (rf) m_rp = (m_rp + 1) % DEPTH;
      if (wgo) m_wrun = 1'b1;
      else if (frame_sync && frame_pos != wr_offset) m_wrun = 1'b0;
      if (rgo) m_rrun = 1'b1;
      else if (frame_sync && frame_pos != rd_offset) m_rrun = 1'b0;
      m_ovf = ovf_ev || (m_ovf && !clr_status);
      m_unf = unf_ev || (m_unf && !clr_status);
   endtask

   task automatic compare_all();
      chk("R3",  "rd_valid",   64'(rd_valid),   64'(m_rv));
      if (m_rv && m_rdv) chk("R4", "rd_data", 64'(rd_data), 64'(m_rd));
      chk("R11", "level",      64'(level),      64'(m_lvl));
      chk("R5",  "k_cnt",      64'(k_cnt),      64'(m_k));
      chk("R6",  "overflow",   64'(overflow),   64'(m_ovf));
      chk("R7",  "underflow",  64'(underflow),  64'(m_unf));
      chk("R2",  "wr_running", 64'(wr_running), 64'(m_wrun));
      chk("R3",  "rd_running", 64'(rd_running), 64'(m_rrun));
      chk("R10", "order_err",  64'(order_err),  64'(rd_offset <= wr_offset));
   endtask

   // one clock: drive at the falling edge, model at the rising edge, compare after
   task automatic cycle(input bit we, input bit re, input bit clr);
      logic [DATA_W-1:0] d;
      d          = $urandom();
      hist[pos]  = d;
      frame_pos  = POS_W'(pos);
      frame_sync = (pos == 0);
      wr_en      = we;
      rd_en      = re;
      clr_status = clr;
      wr_data    = d;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      pos = (pos + 1) % FRAME_LEN;
   endtask

   task automatic idle_to_frame_start();
      while (pos != 0) cycle(1'b0, 1'b0, 1'b0);
   endtask

   task automatic set_offsets(input int w, input int r);
      wr_offset = POS_W'(w);
      rd_offset = POS_W'(r);
   endtask

   initial begin
      void'($urandom(32'd4021));
      for (int i = 0; i < DEPTH; i++) begin
         m_memv[i] = 1'b0;
         m_mem[i]  = '0;
      end
      set_offsets(FRAME_LEN - 1, FRAME_LEN - 1);
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk("R1", "rd_valid in reset", 64'(rd_valid), 64'(0));
      chk("R1", "level in reset", 64'(level), 64'(0));
      chk("R1", "k_cnt in reset", 64'(k_cnt), 64'(0));
      chk("R1", "running in reset", 64'({wr_running, rd_running}), 64'(0));
      chk("R1", "flags in reset", 64'({overflow, underflow}), 64'(0));
      chk("R1", "rd_data in reset", 64'(rd_data), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset", 64'({rd_valid, wr_running, rd_running, overflow, underflow}), 64'(0));

      // R4: steady stream, offsets 10 and 18 give a delay of 8 positions
      set_offsets(10, 18);
      for (int n = 0; n < 2 * FRAME_LEN; n++) begin
         int p;
         p = pos;
         cycle(1'b1, 1'b1, 1'b0);
         if (rd_valid)
            chk("R4", "latency word", 64'(rd_data), 64'(hist[(p - 8 + FRAME_LEN) % FRAME_LEN]));
         if (p == 40) chk("R4", "steady level", 64'(level), 64'(8));
         if (p == 0)  chk("R9", "both stopped at boundary", 64'({wr_running, rd_running}), 64'(0));
      end

      // R6: write far ahead of read fills the store and overflows
      idle_to_frame_start();
      set_offsets(2, 50);
      for (int n = 0; n < FRAME_LEN; n++) cycle(1'b1, 1'b1, 1'b0);
      chk("R6", "overflow raised", 64'(overflow), 64'(1));
      chk("R6", "level held at depth", 64'(level), 64'(DEPTH));
      chk("R7", "no underflow", 64'(underflow), 64'(0));
      // R8: clear with no new event
      cycle(1'b0, 1'b0, 1'b1);
      chk("R8", "flags cleared", 64'({overflow, underflow}), 64'(0));

      // R7: reads with nothing stored
      idle_to_frame_start();
      set_offsets(5, 6);
      for (int n = 0; n < 12; n++) cycle(1'b0, 1'b1, 1'b0);
      chk("R7", "underflow raised", 64'(underflow), 64'(1));
      chk("R7", "read still performed", 64'(rd_valid), 64'(1));
      // R8: clear while a fresh underflow occurs keeps the flag
      cycle(1'b0, 1'b1, 1'b1);
      chk("R8", "set wins over clear", 64'(underflow), 64'(1));
      cycle(1'b0, 1'b0, 1'b1);
      chk("R8", "clear without event", 64'(underflow), 64'(0));

      // R10: offset order flag is combinational
      set_offsets(30, 30);
      #1 chk("R10", "equal offsets", 64'(order_err), 64'(1));
      set_offsets(30, 29);
      #1 chk("R10", "read before write", 64'(order_err), 64'(1));
      set_offsets(29, 30);
      #1 chk("R10", "proper order", 64'(order_err), 64'(0));

      // random frames
      idle_to_frame_start();
      for (int f = 0; f < 60; f++) begin
         int w, r;
         w = $urandom_range(0, 40);
         r = w + $urandom_range(0, 40);
         if (r >= FRAME_LEN) r = FRAME_LEN - 1;
         if ($urandom_range(0, 7) == 0) begin int t; t = w; w = r; r = t; end
         set_offsets(w, r);
         for (int n = 0; n < FRAME_LEN; n++)
            cycle($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                  $urandom_range(0, 15) == 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule